// File: doc/BRIEF.md
# Unaligned Byte Write Packer for Word-Programmed Flash

This block sits between a byte-oriented write source and a flash programmer that accepts only whole, aligned 32-bit words. A write begins with a command that carries a start byte address and a length. Its bytes then arrive one at a time on a valid/ready stream that has a last flag. The block collects the bytes into byte lanes and issues one program request per aligned word. Lanes that the request does not cover are padded with 0xFF, so the flash keeps its current contents in those lanes. No read-modify-write is done.

The downstream programmer keeps each request until it returns a completion pulse with a pass/fail flag. While a word is being programmed, the input stream is stalled. The block keeps a running count of request bytes whose word has been programmed successfully. It finishes every command with a one-cycle done pulse and a status code. A command is rejected before any word is issued if it would run past the end of the device. A zero-length command completes at once.

Top module: `flash_word_packer`

## Requirements
- R1: Every program request carries an address that is a multiple of 4. The first request of a write goes to the start address rounded down to a multiple of 4, and each following request goes to the previous address plus 4.
- R2: Byte lane k of a request holds byte address (request address + k) and sits on data bits 8k+7:8k, so lane 0 is bits 7:0. In the first word, lanes below the start offset are 0xFF.
- R3: Request bytes fill the lanes in stream order, starting at the lane equal to the start address modulo 4 and moving upward.
- R4: When the request ends partway through a word, the bytes already placed stay where they are and every lane above the last request byte is 0xFF. This holds for a trailing word and for a single short word alike.
- R5: Words between the first and the last word of a write carry four request bytes unchanged.
- R6: The byte count is cleared when a command is accepted. It grows by the number of request bytes in a word only after that word is reported successful.
- R7: A command whose start address plus length exceeds DEV_BYTES completes with status 1 (range error), issues no request and leaves the count at 0.
- R8: A zero-length command completes with status 0 (success), issues no request and leaves the count at 0.
- R9: If a request is reported failed, the write stops. Done is pulsed with status 2 (I/O error), no further request is issued, and the count keeps the value it had reached.
- R10: While a request is pending, s_ready is low, and pgm_addr and pgm_data hold steady until pgm_done.
- R11: After reset, cmd_ready is 1, pgm_valid is 0, done is 0 and byte_count is 0.
- R12: After the last word of a write succeeds, done is pulsed with status 0, and byte_count then equals the command length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start-of-write command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Number of bytes in the write |
| s_valid | input | 1 | Stream byte present |
| s_ready | output | 1 | Stream byte accepted this cycle |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of the write |
| pgm_valid | output | 1 | Word program request pending |
| pgm_addr | output | ADDR_W | Aligned word address |
| pgm_data | output | 32 | Word data, lane 0 on bits 7:0 |
| pgm_done | input | 1 | One-cycle completion of the pending request |
| pgm_fail | input | 1 | Qualifies pgm_done as a failure |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 2 | 0 success, 1 range error, 2 I/O error; valid with done |
| byte_count | output | LEN_W | Bytes written successfully in the current command |

## Verification
A lane pointer loaded with the wrong start offset shows up in the very first pgm_data word as a byte in the wrong position or a missing 0xFF pad. A stale word address shows up as a misaligned or repeated pgm_addr at the next request. A fill counter that counts wrong shows up in byte_count right after the pgm_done of the affected word, long before the command ends. A wrong terminal state shows up in the same cycle as the done pulse, either as the wrong status code or as a request issued after a failure or rejection.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    FWP_OK    = 2'd0,
    FWP_RANGE = 2'd1,
    FWP_IOERR = 2'd2
  } fwp_status_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } fwp_state_e;
endpackage

// File: rtl/fwp_range_check.sv
module fwp_range_check #(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 16,
  parameter int DEV_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              zero_len,
  output logic              too_far
);
  localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;
  localparam logic [SUM_W-1:0] DEV_LIM = SUM_W'(DEV_BYTES);

  logic [SUM_W-1:0] end_excl;

  always_comb begin
    end_excl = SUM_W'(addr) + SUM_W'(len);
    zero_len = (len == '0);
    too_far  = (end_excl > DEV_LIM);
  end
endmodule

// File: rtl/fwp_lane_filler.sv
module fwp_lane_filler #(
  parameter int BUS_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [$clog2(BUS_BYTES)-1:0] load_lane,
  input  logic                         put,
  input  logic [7:0]                   put_byte,
  output logic [BUS_BYTES*8-1:0]       word,
  output logic [$clog2(BUS_BYTES)-1:0] lane,
  output logic [$clog2(BUS_BYTES+1)-1:0] fill_cnt,
  output logic                         at_top
);
  localparam int LANE_W = $clog2(BUS_BYTES);
  localparam int CNT_W  = $clog2(BUS_BYTES + 1);
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(BUS_BYTES - 1);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      word     <= '1;
      lane     <= rst ? '0 : load_lane;
      fill_cnt <= '0;
    end else if (put) begin
      for (int i = 0; i < BUS_BYTES; i++) begin
        if (lane == LANE_W'(i)) word[i*8 +: 8] <= put_byte;
      end
      lane     <= lane + 1'b1;
      fill_cnt <= fill_cnt + 1'b1;
    end
  end

  assign at_top = (lane == TOP_LANE);

  // R3
  lane_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (lane == $past(load_lane)) && (fill_cnt == '0) && (word == '1));

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(BUS_BYTES));
endmodule

// File: rtl/flash_word_packer.sv
module flash_word_packer
  import fwp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 16,
  parameter int DEV_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              pgm_valid,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [31:0]       pgm_data,
  input  logic              pgm_done,
  input  logic              pgm_fail,
  output logic              done,
  output logic [1:0]        status,
  output logic [LEN_W-1:0]  byte_count
);
  localparam int BUS_BYTES = 4;
  localparam int LANE_W    = $clog2(BUS_BYTES);
  localparam int CNT_W     = $clog2(BUS_BYTES + 1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BUS_BYTES - 1);

  fwp_state_e           state;
  logic                 last_q;
  logic                 zero_len, too_far;
  logic                 fill_load, fill_put, at_top;
  logic [LANE_W-1:0]    fill_lane, load_lane;
  logic [CNT_W-1:0]     fill_cnt;
  logic                 accept, start_ok, word_ok, word_bad;

  fwp_range_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)
  ) u_range (
    .addr(cmd_addr), .len(cmd_len), .zero_len(zero_len), .too_far(too_far)
  );

  assign cmd_ready = (state == ST_IDLE);
  assign s_ready   = (state == ST_FILL);
  assign pgm_valid = (state == ST_PROG);

  assign accept    = cmd_valid && cmd_ready;
  assign start_ok  = accept && !zero_len && !too_far;
  assign word_ok   = pgm_valid && pgm_done && !pgm_fail;
  assign word_bad  = pgm_valid && pgm_done && pgm_fail;
  assign fill_put  = s_valid && s_ready;
  assign fill_load = start_ok || (word_ok && !last_q);
  assign load_lane = start_ok ? cmd_addr[LANE_W-1:0] : '0;

  fwp_lane_filler #(.BUS_BYTES(BUS_BYTES)) u_fill (
    .clk(clk), .rst(rst),
    .load(fill_load), .load_lane(load_lane),
    .put(fill_put), .put_byte(s_data),
    .word(pgm_data), .lane(fill_lane), .fill_cnt(fill_cnt), .at_top(at_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      last_q     <= 1'b0;
      pgm_addr   <= '0;
      done       <= 1'b0;
      status     <= FWP_OK;
      byte_count <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          byte_count <= '0;
          if (zero_len) begin
            done   <= 1'b1;
            status <= FWP_OK;
          end else if (too_far) begin
            done   <= 1'b1;
            status <= FWP_RANGE;
          end else begin
            pgm_addr <= cmd_addr & ALIGN_MASK;
            state    <= ST_FILL;
          end
        end
        ST_FILL: if (fill_put && (at_top || s_last)) begin
          last_q <= s_last;
          state  <= ST_PROG;
        end
        ST_PROG: if (word_bad) begin
          done   <= 1'b1;
          status <= FWP_IOERR;
          state  <= ST_IDLE;
        end else if (word_ok) begin
          byte_count <= byte_count + LEN_W'(fill_cnt);
          if (last_q) begin
            done   <= 1'b1;
            status <= FWP_OK;
            state  <= ST_IDLE;
          end else begin
            pgm_addr <= pgm_addr + ADDR_W'(BUS_BYTES);
            state    <= ST_FILL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    pgm_valid |-> (pgm_addr[LANE_W-1:0] == '0));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pgm_valid && !pgm_done) |=> pgm_valid && $stable(pgm_addr) && $stable(pgm_data));

  // R10
  stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(s_ready && pgm_valid));

  // R6
  count_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_count != $past(byte_count)) |->
      ($past(pgm_valid && pgm_done && !pgm_fail) || $past(cmd_valid && cmd_ready)));

  // R7
  range_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && too_far && !zero_len) |=> done && (status == FWP_RANGE) && !pgm_valid);

  // R9
  io_stop_chk: assert property (@(posedge clk) disable iff (rst)
    word_bad |=> done && (status == FWP_IOERR) && !pgm_valid && !s_ready);
endmodule

// File: tb/tb_flash_word_packer.sv
module tb_flash_word_packer;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 16;
  localparam int DEV    = 4096;
  localparam int NVEC   = 9;
  // {addr[15:0], len[15:0], fail_word[7:0]} ; fail_word 8'hFF = none
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h0010, 16'd8, 8'hFF},
    {16'h0021, 16'd2, 8'hFF},
    {16'h0033, 16'd6, 8'hFF},
    {16'h0042, 16'd9, 8'h01},
    {16'h0FFC, 16'd4, 8'hFF},
    {16'h0FFD, 16'd4, 8'hFF},
    {16'h0100, 16'd0, 8'hFF},
    {16'h0051, 16'd3, 8'hFF},
    {16'h0061, 16'd5, 8'h00}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic s_valid = 1'b0, s_ready, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic pgm_valid, pgm_done = 1'b0, pgm_fail = 1'b0;
  logic [ADDR_W-1:0] pgm_addr;
  logic [31:0] pgm_data;
  logic done;
  logic [1:0] status;
  logic [LEN_W-1:0] byte_count;

  flash_word_packer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_BYTES(DEV)) dut (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  int cap_n = 0, fail_at = -1, done_cnt = 0;
  logic [ADDR_W-1:0] cap_addr [128];
  logic [31:0]       cap_data [128];
  logic [1:0]        got_status;
  logic [LEN_W-1:0]  got_count;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'((v * 16 + 3) ^ (i * 37));
  endfunction

  // completion monitor
  always @(negedge clk) if (done) begin
    got_status = status;
    got_count  = byte_count;
    done_cnt++;
  end

  // downstream programmer model
  always begin
    @(negedge clk);
    if (pgm_valid && !rst) begin
      logic [ADDR_W-1:0] a0;
      logic [31:0] d0;
      chk(s_ready == 1'b0, "R10 stall", s_ready, 0);
      a0 = pgm_addr; d0 = pgm_data;
      @(negedge clk); @(negedge clk);
      chk(pgm_valid && pgm_addr == a0 && pgm_data == d0, "R10 hold", pgm_data, d0);
      cap_addr[cap_n] = pgm_addr;
      cap_data[cap_n] = pgm_data;
      pgm_fail = (cap_n == fail_at);
      pgm_done = 1'b1;
      cap_n++;
      @(negedge clk);
      pgm_done = 1'b0;
      pgm_fail = 1'b0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(cmd_ready == 1'b1, "R11 cmd_ready", cmd_ready, 1);
    chk(pgm_valid == 1'b0, "R11 pgm_valid", pgm_valid, 0);
    chk(done == 1'b0, "R11 done", done, 0);
    chk(byte_count == '0, "R11 byte_count", byte_count, 0);

    for (int v = 0; v < NVEC; v++) begin
      int a, n, f, base, dbase, nw, expc, exps, issued;
      bit rng;
      a = int'(VEC[v][39:24]); n = int'(VEC[v][23:8]); f = int'(VEC[v][7:0]);
      rng = (a + n > DEV);
      nw = (n == 0 || rng) ? 0 : ((a + n + 3) / 4) - (a / 4);
      base = cap_n; dbase = done_cnt;
      fail_at = (f == 255) ? -1 : base + f;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_addr = ADDR_W'(a); cmd_len = LEN_W'(n);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (nw > 0) begin
        for (int i = 0; i < n; i++) begin
          s_data = pat(v, i); s_last = (i == n - 1); s_valid = 1'b1;
          while (!s_ready && done_cnt == dbase) @(negedge clk);
          if (done_cnt != dbase) break;
          @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
      end
      while (done_cnt == dbase) @(negedge clk);
      repeat (4) @(negedge clk);
      // expected outcome from the requirements
      issued = (f == 255) ? nw : f + 1;
      expc = 0;
      for (int k = 0; k < issued; k++) begin
        int wa; logic [31:0] w; string tg;
        wa = (a & ~3) + 4 * k;
        w = '1;
        for (int l = 0; l < 4; l++) begin
          int b; b = wa + l;
          if (b >= a && b < a + n) begin
            w[l*8 +: 8] = pat(v, b - a);
            if (k < f || f == 255) expc++;
          end
        end
        chk(cap_addr[base + k] == ADDR_W'(wa), "R1 word address", cap_addr[base + k], wa);
        if (k == 0 && (a % 4) != 0) tg = "R2/R3 leading word";
        else if (wa + 4 > a + n) tg = "R4 trailing word";
        else tg = "R5 full word";
        chk(cap_data[base + k] == w, tg, cap_data[base + k], w);
      end
      if (f != 255) begin
        expc = 0;
        for (int k = 0; k < f; k++)
          for (int l = 0; l < 4; l++) begin
            int b; b = (a & ~3) + 4 * k + l;
            if (b >= a && b < a + n) expc++;
          end
      end
      exps = rng && n != 0 ? 1 : (f != 255 ? 2 : 0);
      chk(cap_n - base == issued, n == 0 ? "R8 no words" : (rng ? "R7 no words" : "R9 word total"),
          cap_n - base, issued);
      chk(int'(got_status) == exps,
          n == 0 ? "R8 status" : (rng ? "R7 status" : (f != 255 ? "R9 status" : "R12 status")),
          got_status, exps);
      chk(int'(got_count) == expc, f != 255 ? "R9 count kept" : "R6 count", got_count, expc);
      chk(done_cnt - dbase == 1, "R12 single done", done_cnt - dbase, 1);
    end

    // R6: count advances only after each word succeeds
    begin
      int base;
      base = done_cnt;
      fail_at = -1;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_addr = 16'h0200; cmd_len = 16'd8;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin
        s_data = 8'(i); s_last = 1'b0; s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
      end
      s_valid = 1'b0;
      chk(byte_count == 0, "R6 count before first word done", byte_count, 0);
      while (s_ready == 1'b0) @(negedge clk);
      chk(byte_count == 4, "R6 count after first word", byte_count, 4);
      // R11: reset mid-write returns the port state
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(cmd_ready == 1'b1 && s_ready == 1'b0, "R11 reset mid-write", cmd_ready, 1);
      chk(byte_count == 0, "R11 count after reset", byte_count, 0);
      chk(done_cnt == base, "R11 no done from reset", done_cnt, base);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule